// File: doc/BRIEF.md
# Sized Data Memory Access Unit

A single-port, byte-addressed data memory for a small microcontroller core. Each access carries a size code (8, 16 or 32 bits), a base value and an index value. The unit scales the index by the access width in bytes and adds it to the base to form the effective address. It then aligns the address to the access width and reads or writes little-endian data.

The unit never rejects a misaligned access. Loads are aligned down. A misaligned store does not fault: the unit writes a truncated and shifted copy of the store data at the aligned-down address. The storage size is set by a capability parameter. The memory holds that value times 256 bytes, and the value is driven on an output so the core can find out the size.

Load data is registered. It is valid on the clock after the read strobe, and a one-cycle valid pulse marks it. Loads narrower than 32 bits are zero-extended.

Top module: `dmem_unit`

## Requirements
- R1: Multi-byte values are stored and returned little-endian: the byte at the lowest address is bits 7:0.
- R2: The effective address is base_i + index_i * bytes, where size_i 0 = 8-bit (1 byte), 1 = 16-bit (2 bytes), 2 = 32-bit (4 bytes). Code 3 behaves as 32-bit.
- R3: A 32-bit load ignores the two low effective-address bits and returns the four bytes of the aligned word.
- R4: A 16-bit load ignores effective-address bit 0. 8-bit and 16-bit loads return the value zero-extended to 32 bits.
- R5: A 16-bit store at an odd address writes {wdata_i[7:0], 8'h00} as a halfword at the address aligned down to 2.
- R6: A 32-bit store whose address has bit 0 set writes wdata_i[7:0] shifted left by 8 times the two low address bits. The result is written as a full word at the address aligned down to 4.
- R7: A 32-bit store at an address ending in binary 10 writes wdata_i[15:0] << 16 as a full word at the aligned address.
- R8: Address bits at and above log2(CAP_UNITS*256) are ignored, so accesses wrap within the memory.
- R9: cap_o equals CAP_UNITS. After reset, rdata_o is 0 and rvalid_o is 0.
- R10: rdata_o and rvalid_o update one clock after rd_i. rvalid_o is high for exactly one cycle per read, and rdata_o holds its value while no read is issued.
- R11: An 8-bit store changes only the addressed byte. The other bytes of that word keep their contents.
- R12: When rd_i and wr_i are asserted in the same cycle, the read returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| size_i | input | 2 | Access size code |
| base_i | input | 32 | Base value of the address |
| index_i | input | 32 | Index, scaled by access width |
| wdata_i | input | 32 | Store data |
| rd_i | input | 1 | Load strobe |
| wr_i | input | 1 | Store strobe |
| rdata_o | output | 32 | Registered, zero-extended load data |
| rvalid_o | output | 1 | Load data valid pulse |
| cap_o | output | 8 | Memory size in units of 256 bytes |

## Verification
Any fault in the stored lanes, the lane enables or the store mangling stays hidden until a later load reads that word back. At that point it shows on rdata_o one clock after rd_i. A wrong registered size or offset shows up right away as the wrong byte selected, or as nonzero upper bits on a narrow load. The bench therefore reads back every word it writes, with more than one load width. A broken wrap shows as wrong data from an alias address on the read that follows.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int unsigned LANES = 4;
endpackage

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen #(
  parameter int unsigned AW = 10
) (
  input  logic [1:0]    size_i,
  input  logic [31:0]   base_i,
  input  logic [31:0]   index_i,
  output logic [AW-3:0] word_o,
  output logic [1:0]    ofs_o
);
  import dmem_pkg::*;
  logic [31:0] scaled;
  logic [31:0] ea;

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: scaled = index_i;
      SZ_HALF: scaled = index_i << 1;
      default: scaled = index_i << 2;
    endcase
    ea = base_i + scaled;
  end

  // upper bits dropped: wrap within depth
  assign word_o = ea[AW-1:2];
  assign ofs_o  = ea[1:0];

  always_comb begin
    // R2
    scaled_chk: assert (size_i == 2'd0 || scaled[0] == 1'b0);
  end
endmodule

// File: rtl/dmem_store_fmt.sv
module dmem_store_fmt (
  input  logic [1:0]  size_i,
  input  logic [1:0]  ofs_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] lane_data_o,
  output logic [3:0]  lane_en_o
);
  import dmem_pkg::*;
  logic [15:0] half_v;

  always_comb begin
    half_v      = ofs_i[0] ? {wdata_i[7:0], 8'h00} : wdata_i[15:0];
    lane_data_o = wdata_i;
    lane_en_o   = 4'b1111;
    unique case (acc_size_e'(size_i))
      SZ_BYTE: begin
        lane_data_o = {4{wdata_i[7:0]}};
        lane_en_o   = 4'b0001 << ofs_i;
      end
      SZ_HALF: begin
        lane_data_o = {2{half_v}};
        lane_en_o   = ofs_i[1] ? 4'b1100 : 4'b0011;
      end
      default: begin
        if (ofs_i[0])      lane_data_o = {24'h0, wdata_i[7:0]} << {ofs_i, 3'b000};
        else if (ofs_i[1]) lane_data_o = {wdata_i[15:0], 16'h0};
        else               lane_data_o = wdata_i;
      end
    endcase
  end

  always_comb begin
    // R11
    byte_lane_chk: assert (size_i != 2'd0 || $countones(lane_en_o) == 1);
    // R5
    half_odd_chk: assert (!(size_i == 2'd1 && ofs_i[0]) || half_v[7:0] == 8'h00);
  end
endmodule

// File: rtl/dmem_bank.sv
module dmem_bank #(
  parameter int unsigned WORDS = 256,
  localparam int unsigned WAW = $clog2(WORDS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rd_i,
  input  logic           wr_i,
  input  logic [WAW-1:0] word_i,
  input  logic [31:0]    lane_data_i,
  input  logic [3:0]     lane_en_i,
  output logic [31:0]    rword_o
);
  import dmem_pkg::*;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem_q [WORDS];
    logic [7:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (wr_i && lane_en_i[l]) mem_q[word_i] <= lane_data_i[8*l +: 8];
    end

    // read-before-write on same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_q <= '0;
      else if (rd_i) rd_q <= mem_q[word_i];
    end

    assign rword_o[8*l +: 8] = rd_q;
  end
endmodule

// File: rtl/dmem_load_fmt.sv
module dmem_load_fmt (
  input  logic [1:0]  size_i,
  input  logic [1:0]  ofs_i,
  input  logic [31:0] rword_i,
  output logic [31:0] rdata_o
);
  import dmem_pkg::*;

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: rdata_o = {24'h0, rword_i[8*ofs_i +: 8]};
      SZ_HALF: rdata_o = {16'h0, ofs_i[1] ? rword_i[31:16] : rword_i[15:0]};
      default: rdata_o = rword_i;
    endcase
  end
endmodule

// File: rtl/dmem_unit.sv
module dmem_unit #(
  parameter int unsigned CAP_W     = 8,
  parameter int unsigned CAP_UNITS = 4,
  localparam int unsigned BYTES = CAP_UNITS << 8,
  localparam int unsigned AW    = $clog2(BYTES),
  localparam int unsigned WORDS = BYTES / 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       size_i,
  input  logic [31:0]      base_i,
  input  logic [31:0]      index_i,
  input  logic [31:0]      wdata_i,
  input  logic             rd_i,
  input  logic             wr_i,
  output logic [31:0]      rdata_o,
  output logic             rvalid_o,
  output logic [CAP_W-1:0] cap_o
);
  logic [AW-3:0] word;
  logic [1:0]    ofs;
  logic [31:0]   lane_data;
  logic [3:0]    lane_en;
  logic [31:0]   rword;
  logic [1:0]    rd_sz_q;
  logic [1:0]    rd_ofs_q;
  logic          rvalid_q;

  assign cap_o = CAP_W'(CAP_UNITS);

  dmem_addr_gen #(.AW(AW)) u_addr (
    .size_i (size_i),
    .base_i (base_i),
    .index_i(index_i),
    .word_o (word),
    .ofs_o  (ofs)
  );

  dmem_store_fmt u_stfmt (
    .size_i     (size_i),
    .ofs_i      (ofs),
    .wdata_i    (wdata_i),
    .lane_data_o(lane_data),
    .lane_en_o  (lane_en)
  );

  dmem_bank #(.WORDS(WORDS)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .word_i     (word),
    .lane_data_i(lane_data),
    .lane_en_i  (lane_en),
    .rword_o    (rword)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_sz_q  <= 2'd2;
      rd_ofs_q <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) begin
        rd_sz_q  <= size_i;
        rd_ofs_q <= ofs;
      end
    end
  end

  dmem_load_fmt u_ldfmt (
    .size_i (rd_sz_q),
    .ofs_i  (rd_ofs_q),
    .rword_i(rword),
    .rdata_o(rdata_o)
  );

  assign rvalid_o = rvalid_q;

  // R10
  rvalid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) rd_i |=> rvalid_o);
  // R10
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !rd_i |=> !rvalid_o);
  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !rd_i |=> $stable(rdata_o));
  // R4
  zero_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && size_i == 2'd0) |=> rdata_o[31:8] == 24'h0);
  // R4
  half_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && size_i == 2'd1) |=> rdata_o[31:16] == 16'h0);
endmodule

// File: tb/dmem_unit_bench.sv
module dmem_unit_bench;
  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] base;
    logic [31:0] idx;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 32'h100, 32'd0, 32'h11223344, 32'h0,        4'd1},  // R1 write
    '{1'b0, 2'd2, 32'h100, 32'd0, 32'h0,        32'h11223344, 4'd1},  // R1
    '{1'b0, 2'd0, 32'h100, 32'd2, 32'h0,        32'h00000022, 4'd2},  // R2 byte idx
    '{1'b0, 2'd1, 32'h100, 32'd1, 32'h0,        32'h00001122, 4'd2},  // R2 half idx
    '{1'b0, 2'd1, 32'h103, 32'd0, 32'h0,        32'h00001122, 4'd4},  // R4 align 2
    '{1'b0, 2'd2, 32'h101, 32'd0, 32'h0,        32'h11223344, 4'd3},  // R3 align 4
    '{1'b0, 2'd2, 32'h0FC, 32'd1, 32'h0,        32'h11223344, 4'd2},  // R2 word idx
    '{1'b0, 2'd3, 32'h0F8, 32'd2, 32'h0,        32'h11223344, 4'd2},  // R2 code 3
    '{1'b1, 2'd0, 32'h100, 32'd1, 32'hAAAAAA55, 32'h0,        4'd11}, // R11 write
    '{1'b0, 2'd2, 32'h100, 32'd0, 32'h0,        32'h11225544, 4'd11}, // R11
    '{1'b1, 2'd1, 32'h105, 32'd0, 32'h0000BEEF, 32'h0,        4'd5},  // R5 write
    '{1'b0, 2'd1, 32'h104, 32'd0, 32'h0,        32'h0000EF00, 4'd5},  // R5
    '{1'b1, 2'd2, 32'h109, 32'd0, 32'hCAFEBABE, 32'h0,        4'd6},  // R6 write
    '{1'b0, 2'd2, 32'h108, 32'd0, 32'h0,        32'h0000BE00, 4'd6},  // R6 ofs 1
    '{1'b1, 2'd2, 32'h10F, 32'd0, 32'hCAFEBABE, 32'h0,        4'd6},  // R6 write
    '{1'b0, 2'd2, 32'h10C, 32'd0, 32'h0,        32'hBE000000, 4'd6},  // R6 ofs 3
    '{1'b1, 2'd2, 32'h112, 32'd0, 32'hCAFEBABE, 32'h0,        4'd7},  // R7 write
    '{1'b0, 2'd2, 32'h110, 32'd0, 32'h0,        32'hBABE0000, 4'd7},  // R7
    '{1'b0, 2'd2, 32'h500, 32'd0, 32'h0,        32'h11225544, 4'd8},  // R8 wrap
    '{1'b0, 2'd0, 32'hFFFFFD01, 32'd0, 32'h0,   32'h00000055, 4'd8}   // R8 wrap high
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  size = '0;
  logic [31:0] base = '0, index = '0, wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [7:0]  cap;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dmem_unit u_dmem_unit (
    .clk_i(clk), .rst_ni(rst_n), .size_i(size), .base_i(base), .index_i(index),
    .wdata_i(wdata), .rd_i(rd), .wr_i(wr), .rdata_o(rdata), .rvalid_o(rvalid), .cap_o(cap)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic r, input logic [1:0] s,
                        input logic [31:0] b, input logic [31:0] i, input logic [31:0] d);
    @(negedge clk);
    wr = w; rd = r; size = s; base = b; index = i; wdata = d;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state and capability
    check("R9 rdata", rdata, 32'h0);
    check("R9 rvalid", {31'h0, rvalid}, 32'h1 & 32'h0);
    check("R9 cap", {24'h0, cap}, 32'd4);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      access(VECS[k].wr, !VECS[k].wr, VECS[k].sz, VECS[k].base, VECS[k].idx, VECS[k].wdata);
      if (!VECS[k].wr) check($sformatf("R%0d vec%0d", VECS[k].req, k), rdata, VECS[k].exp);
    end

    // R10 valid pulse and hold
    access(1'b0, 1'b1, 2'd0, 32'h102, 32'd0, 32'h0);
    check("R10 rvalid high", {31'h0, rvalid}, 32'h1);
    check("R10 data", rdata, 32'h00000022);
    @(negedge clk);
    check("R10 rvalid low", {31'h0, rvalid}, 32'h0);
    size = 2'd2; base = 32'h108;
    @(negedge clk);
    check("R10 hold", rdata, 32'h00000022);

    // R12 simultaneous read and write
    access(1'b1, 1'b1, 2'd2, 32'h100, 32'd0, 32'h99887766);
    check("R12 old data", rdata, 32'h11225544);
    access(1'b0, 1'b1, 2'd2, 32'h100, 32'd0, 32'h0);
    check("R12 new data", rdata, 32'h99887766);

    // R4 byte zero-extend of high byte
    access(1'b0, 1'b1, 2'd0, 32'h103, 32'd0, 32'h0);
    check("R4 byte ext", rdata, 32'h00000099);
    // R1 halfword store then bytes
    access(1'b1, 1'b0, 2'd1, 32'h200, 32'd3, 32'h00001234);
    access(1'b0, 1'b1, 2'd0, 32'h207, 32'd0, 32'h0);
    check("R1 half hi byte", rdata, 32'h00000012);
    access(1'b0, 1'b1, 2'd0, 32'h206, 32'd0, 32'h0);
    check("R1 half lo byte", rdata, 32'h00000034);

    // R9 reset clears outputs again
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset rdata", rdata, 32'h0);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule